// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port Controller

This block is one general-purpose I/O port of sixteen pins. Software configures each pin through a 4-bit field held in one of two 32-bit configuration registers. Each pin can be set up as an analog input, a floating input, an input with a pull resistor, or an output. Outputs can be push-pull or open-drain, and each output takes its value either from the port's output latch or from a per-pin alternate-function input. The block drives the pad's output value, output enable and the two pull controls, and it synchronises pad levels into an input data register that software can read.

Software changes the output latch in one of two ways. A full write to the output data register replaces all sixteen bits at once. A write to the set/clear register changes only the bits that are named in the write, so no read-modify-write is needed. In pull-input mode the latch bit of that pin chooses the pull direction. A synchronous port reset puts every pin back to floating input and clears the latch. The register interface is a plain write strobe with an address. Read data is combinational from the address.

Top module: `gpio_port_ctl`

## Requirements
- R1: Pin p owns the 4-bit field {cnf[1:0], mode[1:0]}. Pins 0 to 7 sit in the low configuration register (address 0) and pins 8 to 15 in the high one (address 1), at bit offset 4*(p mod 8). Both registers read back exactly what was written.
- R2: With mode 00 the pin is an input: padOe and padOut are 0. Field 0000 (analog) gives no pull and reads 0 in the input data register. cnf 01 (floating) and cnf 11 give no pull.
- R3: With mode 00 and cnf 10, pullUp equals the pin's output latch bit and pullDown is its inverse. In every other configuration both pull controls are 0.
- R4: With mode not 00 and cnf[0]=0 (push-pull), padOe is 1 and padOut equals the pin's drive source.
- R5: With mode not 00 and cnf[0]=1 (open-drain), padOut is 0 and padOe is 1 only while the drive source is 0.
- R6: In output mode the drive source is altIn[p] when cnf[1]=1, and output latch bit p when cnf[1]=0.
- R7: A write to the set/clear register (address 4) sets latch bit i when wrData[i] is 1 and clears it when wrData[16+i] is 1. Latch bits with neither bit set are left unchanged.
- R8: When one set/clear write has both wrData[i] and wrData[16+i] set, latch bit i becomes 1.
- R9: A write to the output data register (address 3) replaces all sixteen latch bits with wrData[15:0]. A read of address 3 returns the latch in bits 15:0, and a read of address 4 returns 0.
- R10: A read of address 2 returns, for each non-analog pin, the pad level sampled two clock edges earlier. Bits 31:16 read as 0.
- R11: While portRst is high at a clock edge, both configuration registers become 32'h44444444 (every pin floating input, field 0100) and the output latch becomes 0.
- R12: Addresses 5 to 7 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| portRst | input | 1 | Synchronous port reset, active high |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr (combinational) |
| padIn | input | 16 | Pad levels, asynchronous |
| altIn | input | 16 | Alternate-function drive values |
| padOut | output | 16 | Pad output value |
| padOe | output | 16 | Pad output enable |
| pullUp | output | 16 | Pull-up enable |
| pullDown | output | 16 | Pull-down enable |

## Verification
A wrong configuration field shows at the pad controls in the same cycle, and it shows in read data as soon as the register is addressed. A corrupted output latch bit shows on padOut or padOe for output pins, or on pullUp and pullDown for pull inputs, on the cycle after the faulty write. A synchroniser fault shows in the input data register as a level that is one cycle early or one cycle late. The bench compares every pad control and the read data against a behavioural model on every cycle, so each of these faults is caught within one cycle of becoming visible.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PIN_COUNT    = 16;
  localparam int FIELD_W      = 4;
  localparam int BUS_W        = 32;
  localparam int ADDR_W       = 3;
  localparam int PINS_PER_CFG = BUS_W / FIELD_W;
  localparam int CFG_BITS     = PIN_COUNT * FIELD_W;

  localparam logic [ADDR_W-1:0] ADDR_CFG_LO = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CFG_HI = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_IN     = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_OUT    = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_SETCLR = 3'd4;

  localparam logic [FIELD_W-1:0] CFG_RESET = 4'b0100;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CFG_LO,
    RD_CFG_HI,
    RD_IN,
    RD_OUT
  } rdSel_e;

  typedef struct packed {
    logic   wrCfgLo;
    logic   wrCfgHi;
    logic   wrOut;
    logic   wrSetClr;
    rdSel_e rdSel;
  } portStrobe_t;
endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
  import gpio_port_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output portStrobe_t       strobe
);
  always_comb begin
    strobe = '{wrCfgLo: 1'b0, wrCfgHi: 1'b0, wrOut: 1'b0, wrSetClr: 1'b0, rdSel: RD_NONE};
    case (addr)
      ADDR_CFG_LO: begin strobe.wrCfgLo  = wrEn; strobe.rdSel = RD_CFG_LO; end
      ADDR_CFG_HI: begin strobe.wrCfgHi  = wrEn; strobe.rdSel = RD_CFG_HI; end
      ADDR_IN:     begin strobe.rdSel    = RD_IN; end
      ADDR_OUT:    begin strobe.wrOut    = wrEn; strobe.rdSel = RD_OUT; end
      ADDR_SETCLR: begin strobe.wrSetClr = wrEn; end
      default:     ;
    endcase
  end
endmodule

// File: rtl/gpio_port_core.sv
module gpio_port_core
  import gpio_port_pkg::*;
(
  input  logic                 clk,
  input  logic                 portRst,
  input  portStrobe_t          strobe,
  input  logic [BUS_W-1:0]     wrData,
  input  logic [PIN_COUNT-1:0] padIn,
  input  logic [PIN_COUNT-1:0] altIn,
  output logic [BUS_W-1:0]     rdData,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] pullUp,
  output logic [PIN_COUNT-1:0] pullDown
);
  localparam logic [BUS_W-1:0] CFG_RESET_WORD = {PINS_PER_CFG{CFG_RESET}};

  logic [BUS_W-1:0]     cfgLo, cfgHi;
  logic [CFG_BITS-1:0]  cfgAll;
  logic [PIN_COUNT-1:0] outLatch, latchNext;
  logic [PIN_COUNT-1:0] setMask, clrMask;
  logic [PIN_COUNT-1:0] syncA, syncB, inData;

  assign cfgAll  = {cfgHi, cfgLo};
  assign setMask = wrData[PIN_COUNT-1:0];
  assign clrMask = wrData[2*PIN_COUNT-1:PIN_COUNT];

  // configuration registers
  always_ff @(posedge clk) begin
    if (portRst) begin
      cfgLo <= CFG_RESET_WORD;
      cfgHi <= CFG_RESET_WORD;
    end else begin
      if (strobe.wrCfgLo) cfgLo <= wrData;
      if (strobe.wrCfgHi) cfgHi <= wrData;
    end
  end

  // output latch: set wins over clear
  always_comb begin
    latchNext = outLatch;
    if (strobe.wrOut)    latchNext = wrData[PIN_COUNT-1:0];
    if (strobe.wrSetClr) latchNext = (outLatch & ~clrMask) | setMask;
  end

  always_ff @(posedge clk) begin
    if (portRst) outLatch <= '0;
    else         outLatch <= latchNext;
  end

  // two-flop pad synchroniser
  always_ff @(posedge clk) begin
    syncA <= padIn;
    syncB <= syncA;
  end

  // per-pin pad control
  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    logic [1:0] mode, cnf;
    logic isOut, isOd, pullSel, src;
    assign mode    = cfgAll[p*FIELD_W +: 2];
    assign cnf     = cfgAll[p*FIELD_W+2 +: 2];
    assign isOut   = |mode;
    assign isOd    = cnf[0];
    assign src     = cnf[1] ? altIn[p] : outLatch[p];
    assign pullSel = !isOut && (cnf == 2'b10);
    assign padOe[p]    = isOut & ~(isOd & src);
    assign padOut[p]   = isOut & ~isOd & src;
    assign pullUp[p]   = pullSel & outLatch[p];
    assign pullDown[p] = pullSel & ~outLatch[p];
    assign inData[p]   = (|{cnf, mode}) & syncB[p];
  end

  // read mux
  always_comb begin
    case (strobe.rdSel)
      RD_CFG_LO: rdData = cfgLo;
      RD_CFG_HI: rdData = cfgHi;
      RD_IN:     rdData = {{(BUS_W-PIN_COUNT){1'b0}}, inData};
      RD_OUT:    rdData = {{(BUS_W-PIN_COUNT){1'b0}}, outLatch};
      default:   rdData = '0;
    endcase
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (portRst)
    strobe.wrSetClr |=> ((outLatch & $past(setMask)) == $past(setMask))); // R8
  AST_CLR_APPLIES: assert property (@(posedge clk) disable iff (portRst)
    strobe.wrSetClr |=> ((outLatch & $past(clrMask & ~setMask)) == '0)); // R7
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (portRst)
    (!strobe.wrSetClr && !strobe.wrOut) |=> $stable(outLatch)); // R7
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (portRst)
    $fell(portRst) |-> (cfgLo == CFG_RESET_WORD && cfgHi == CFG_RESET_WORD && outLatch == '0)); // R11
  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (portRst)
    syncB == $past(padIn, 2)); // R10
  AST_PULL_EXCL: assert property (@(posedge clk) disable iff (portRst)
    (pullUp & pullDown) == '0); // R3
  AST_PULL_NO_DRIVE: assert property (@(posedge clk) disable iff (portRst)
    ((pullUp | pullDown) & padOe) == '0); // R2
  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (portRst)
    (padOut & ~padOe) == '0); // R5
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_port_pkg::*;
(
  input  logic                 clk,
  input  logic                 portRst,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BUS_W-1:0]     wrData,
  output logic [BUS_W-1:0]     rdData,
  input  logic [PIN_COUNT-1:0] padIn,
  input  logic [PIN_COUNT-1:0] altIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] pullUp,
  output logic [PIN_COUNT-1:0] pullDown
);
  portStrobe_t strobe;

  gpio_port_decode u_decode (
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe)
  );

  gpio_port_core u_core (
    .clk      (clk),
    .portRst  (portRst),
    .strobe   (strobe),
    .wrData   (wrData),
    .padIn    (padIn),
    .altIn    (altIn),
    .rdData   (rdData),
    .padOut   (padOut),
    .padOe    (padOe),
    .pullUp   (pullUp),
    .pullDown (pullDown)
  );
endmodule

// File: tb/tb_gpio_port_ctl.sv
`timescale 1ns/1ps
module tb_gpio_port_ctl;
  logic        clk = 1'b0;
  logic        portRst, wrEn;
  logic [2:0]  addr;
  logic [31:0] wrData, rdData;
  logic [15:0] padIn, altIn, padOut, padOe, pullUp, pullDown;

  int checks = 0;
  int failures = 0;
  bit cmpOn = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port_ctl dut (
    .clk(clk), .portRst(portRst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .altIn(altIn), .padOut(padOut),
    .padOe(padOe), .pullUp(pullUp), .pullDown(pullDown)
  );

  // behavioural reference model
  logic [3:0]  mCfg [16];
  logic [15:0] mLat;
  logic [15:0] hist [$];

  always @(posedge clk) begin
    hist.push_front(padIn);
    if (hist.size() > 2) void'(hist.pop_back());
    if (portRst) begin
      for (int i = 0; i < 16; i++) mCfg[i] = 4'b0100;
      mLat = '0;
    end else if (wrEn) begin
      case (addr)
        3'd0: for (int i = 0; i < 8; i++) mCfg[i]   = wrData[4*i +: 4];
        3'd1: for (int i = 0; i < 8; i++) mCfg[i+8] = wrData[4*i +: 4];
        3'd3: mLat = wrData[15:0];
        3'd4: mLat = (mLat & ~wrData[31:16]) | wrData[15:0];
        default: ;
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [2:0] a);
    logic [31:0] v = '0;
    case (a)
      3'd0: for (int i = 0; i < 8; i++) v[4*i +: 4] = mCfg[i];
      3'd1: for (int i = 0; i < 8; i++) v[4*i +: 4] = mCfg[i+8];
      3'd2: for (int i = 0; i < 16; i++) v[i] = (mCfg[i] == 4'b0000) ? 1'b0 : hist[1][i];
      3'd3: v[15:0] = mLat;
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(negedge clk) begin
    if (cmpOn && hist.size() == 2) begin
      logic [15:0] eOut, eOe, eUp, eDn;
      logic [31:0] eRd;
      for (int i = 0; i < 16; i++) begin
        int cnf, md;
        bit src;
        cnf = int'(mCfg[i][3:2]);
        md  = int'(mCfg[i][1:0]);
        src = (cnf >= 2) ? altIn[i] : mLat[i];
        eOut[i] = 0; eOe[i] = 0; eUp[i] = 0; eDn[i] = 0;
        if (md == 0) begin
          if (cnf == 2) begin eUp[i] = mLat[i]; eDn[i] = !mLat[i]; end
        end else if (cnf % 2 == 0) begin
          eOut[i] = src; eOe[i] = 1;
        end else begin
          eOe[i] = !src;
        end
      end
      eRd = expRead(addr);
      check(padOut === eOut, "R4 R5 R6 padOut", {16'h0, padOut}, {16'h0, eOut});
      check(padOe === eOe, "R2 R4 R5 R6 padOe", {16'h0, padOe}, {16'h0, eOe});
      check(pullUp === eUp, "R3 pullUp", {16'h0, pullUp}, {16'h0, eUp});
      check(pullDown === eDn, "R3 pullDown", {16'h0, pullDown}, {16'h0, eDn});
      check(rdData === eRd, "R1 R9 R10 R12 rdData", rdData, eRd);
    end
  end

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1; wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1; wrEn = 1'b0;
  endtask

  task automatic readChk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1; addr = a;
    @(negedge clk);
    check(rdData === exp, tag, rdData, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    portRst = 1'b1; wrEn = 1'b0; addr = '0; wrData = '0; padIn = '0; altIn = '0;
    repeat (4) @(posedge clk);
    #1; portRst = 1'b0; cmpOn = 1'b1;

    readChk(3'd0, 32'h44444444, "R1 R11 low config reset");
    readChk(3'd1, 32'h44444444, "R11 high config reset");
    readChk(3'd3, 32'h0, "R11 latch reset");
    check(padOe === 16'h0, "R11 no drive after reset", {16'h0, padOe}, 32'h0);

    // p0 pp, p1 od, p2 alt pp, p3 alt od, p4 analog, p5 pull, p6 float, p7 pull
    writeReg(3'd0, 32'h8480FB73);
    readChk(3'd0, 32'h8480FB73, "R1 low config readback");
    writeReg(3'd1, 32'h44444441);
    readChk(3'd1, 32'h44444441, "R1 high config readback");

    writeReg(3'd4, 32'h000000A1);
    readChk(3'd3, 32'h000000A1, "R7 set bits");
    check(padOut[0] === 1'b1 && padOe[0] === 1'b1, "R4 push-pull drives 1", {30'h0, padOut[0], padOe[0]}, 32'h3);
    check(pullUp[5] === 1'b1, "R3 pull-up from latch 1", {31'h0, pullUp[5]}, 32'h1);
    check(padOe[1] === 1'b1 && padOut[1] === 1'b0, "R5 open-drain sinks 0", {30'h0, padOut[1], padOe[1]}, 32'h1);

    writeReg(3'd4, 32'h00010002);
    readChk(3'd3, 32'h000000A2, "R7 clear and keep");
    check(padOe[1] === 1'b0, "R5 open-drain releases 1", {31'h0, padOe[1]}, 32'h0);

    writeReg(3'd4, 32'h00080008);
    readChk(3'd3, 32'h000000AA, "R8 set beats clear");

    writeReg(3'd4, 32'h00200000);
    check(pullDown[5] === 1'b1 && pullUp[5] === 1'b0, "R3 pull-down from latch 0", {30'h0, pullUp[5], pullDown[5]}, 32'h1);

    @(posedge clk); #1; altIn = 16'h0004;
    @(negedge clk);
    check(padOut[2] === 1'b1 && padOe[2] === 1'b1, "R6 alt push-pull follows altIn", {30'h0, padOut[2], padOe[2]}, 32'h3);
    check(padOe[3] === 1'b1, "R6 alt open-drain ignores latch", {31'h0, padOe[3]}, 32'h1);
    @(posedge clk); #1; altIn = 16'h0008;
    @(negedge clk);
    check(padOut[2] === 1'b0 && padOe[3] === 1'b0, "R6 alt values swapped", {30'h0, padOut[2], padOe[3]}, 32'h0);

    readChk(3'd4, 32'h0, "R9 set/clear reads zero");
    writeReg(3'd3, 32'hFFFF1234);
    readChk(3'd3, 32'h00001234, "R9 full latch write");

    writeReg(3'd7, 32'hFFFFFFFF);
    readChk(3'd7, 32'h0, "R12 unmapped reads zero");
    readChk(3'd3, 32'h00001234, "R12 latch untouched");
    readChk(3'd0, 32'h8480FB73, "R12 config untouched");

    @(posedge clk); #1; padIn = 16'h0050; addr = 3'd2;
    @(negedge clk);
    check(rdData[6] === 1'b0, "R10 no edge yet", {31'h0, rdData[6]}, 32'h0);
    @(negedge clk);
    check(rdData[6] === 1'b0, "R10 one edge", {31'h0, rdData[6]}, 32'h0);
    @(negedge clk);
    check(rdData[6] === 1'b1, "R10 two edges", {31'h0, rdData[6]}, 32'h1);
    check(rdData[4] === 1'b0, "R2 analog reads zero", {31'h0, rdData[4]}, 32'h0);

    for (int n = 0; n < 3000; n++) begin
      @(posedge clk); #1;
      padIn   = 16'($urandom);
      altIn   = 16'($urandom);
      wrEn    = ($urandom % 3) == 0;
      addr    = 3'($urandom);
      wrData  = $urandom;
      portRst = ($urandom % 250) == 0;
    end
    @(posedge clk); #1; wrEn = 1'b0; portRst = 1'b1;
    @(posedge clk); #1; portRst = 1'b0;
    readChk(3'd0, 32'h44444444, "R11 reset mid-run low");
    readChk(3'd1, 32'h44444444, "R11 reset mid-run high");
    readChk(3'd3, 32'h0, "R11 reset mid-run latch");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule